// File: doc/BRIEF.md
# 10BASE-T Half-Duplex Heartbeat and Receive Steering

This block sits between the MAC-side transmit and receive nibbles and the line-side receive path of a 10/100 transceiver. When 10BASE-T operation is active, it produces the signal quality error test pulse, also called the heartbeat. Each time the transmit enable input goes low, it waits one microsecond and then drives the collision output high for one microsecond. A real collision indication from the line-side detector always reaches the collision output as well.

The block also sets the receive nibble. In 10BASE-T half duplex with loopback enabled, when the port transmits and the line is quiet, the transmit nibble is sent back to the MAC on the receive nibble. Otherwise the line data passes through. The block also produces carrier sense. In repeater mode the heartbeat is never generated, carrier sense follows only receive activity, and the port always acts as half duplex. Both microsecond windows are counted in clock cycles from the clock frequency parameter.

Top module: `hd10_sqe_ctrl`

## Requirements
- R1: After reset the collision output is low, and with no stimulus it stays low because no heartbeat is pending.
- R2: With 10BASE-T mode on, heartbeat enabled and repeater mode off, a clock edge that samples transmit enable low after it was high starts the heartbeat. Call that edge E0. The collision output is high after edges E(N) to E(2N-1) and low after every other edge, where N is the number of clock cycles in one microsecond (the frequency in MHz).
- R3: When the heartbeat-disable bit is set, no heartbeat is produced. If the bit is set during the wait or the pulse, the collision output is low from the next edge on.
- R4: When repeater mode is set, no heartbeat is produced. This includes a window that is already running.
- R5: When 10BASE-T mode is off, no heartbeat is produced.
- R6: If transmit enable rises during the wait or the pulse, the heartbeat is cancelled. The collision output is low after the next edge and stays low.
- R7: When the collision detect input is high, the collision output is high in the same cycle.
- R8: The receive nibble equals the transmit nibble when all of these hold: 10BASE-T mode is on, the port is half duplex (the half-duplex bit or repeater mode is set), loopback is enabled, transmit enable is high, receive activity is low and collision detect is low.
- R9: When receive activity or collision detect is high, the receive nibble equals the line receive nibble.
- R10: The receive nibble equals the line receive nibble in any of these cases: loopback is disabled, 10BASE-T mode is off, or the port is in full duplex with repeater mode off.
- R11: With repeater mode off, carrier sense is (transmit enable OR receive activity) in half duplex, and receive activity alone in full duplex.
- R12: With repeater mode on, carrier sense equals receive activity, and the port is treated as half duplex for R8 even when the half-duplex bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_FREQ_MHZ |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| txd | input | 4 | Transmit nibble from the MAC |
| line_rxd | input | 4 | Receive nibble decoded from the line |
| rx_active | input | 1 | Receive activity on the line |
| coll_det | input | 1 | Collision detected on the line |
| mode_10bt | input | 1 | 10BASE-T speed selected |
| half_dup | input | 1 | Half duplex selected |
| rptr_mode | input | 1 | Repeater mode |
| sqe_off | input | 1 | Heartbeat disable |
| lpbk_en | input | 1 | Loopback enable |
| col | output | 1 | Collision output to the MAC |
| crs | output | 1 | Carrier sense to the MAC |
| rxd | output | 4 | Receive nibble to the MAC |

## Verification
The heartbeat state machine is the only stored state. A wrong count or a wrong state shows up on the collision output within two microseconds of a transmit-enable fall, as a pulse that starts at the wrong time, has the wrong width, or is missing. A failed cancel or suppression shows up one cycle after transmit enable rises or the disable bit is set. The steering and carrier sense paths are combinational, so a fault there shows on the receive nibble or carrier sense in the same cycle as the input that causes it.

// File: rtl/hd10_pkg.sv
package hd10_pkg;

    typedef enum logic [1:0] {
        HB_IDLE  = 2'd0,
        HB_WAIT  = 2'd1,
        HB_PULSE = 2'd2
    } hb_state_t;

    typedef struct packed {
        logic ten_base;
        logic half;
        logic rptr;
        logic hb_off;
        logic lpbk;
    } port_mode_t;

    // Repeater mode forbids full duplex, so it forces half duplex.
    function automatic logic eff_half(port_mode_t m);
        return m.half | m.rptr;
    endfunction

    function automatic logic hb_allowed(port_mode_t m);
        return m.ten_base & ~m.hb_off & ~m.rptr;
    endfunction

    function automatic logic loop_allowed(port_mode_t m);
        return m.ten_base & eff_half(m) & m.lpbk;
    endfunction

endpackage

// File: rtl/hd10_hb_timer.sv
module hd10_hb_timer
    import hd10_pkg::*;
#(
    parameter int CYC_PER_US = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic arm_ok,
    output logic hb_on
);
    localparam int CW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_US - 1);

    hb_state_t st;
    logic [CW-1:0] cnt;
    logic tx_q;
    logic tx_rise, tx_fall;

    assign tx_rise = tx_en & ~tx_q;
    assign tx_fall = ~tx_en & tx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= HB_IDLE;
            cnt  <= '0;
            tx_q <= 1'b0;
        end else begin
            tx_q <= tx_en;
            if (!arm_ok || tx_rise) begin
                st  <= HB_IDLE;
                cnt <= '0;
            end else begin
                case (st)
                    HB_IDLE: begin
                        cnt <= '0;
                        if (tx_fall) st <= HB_WAIT;
                    end
                    HB_WAIT: begin
                        if (cnt == LAST) begin
                            st  <= HB_PULSE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    HB_PULSE: begin
                        if (cnt == LAST) begin
                            st  <= HB_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        st  <= HB_IDLE;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    assign hb_on = (st == HB_PULSE);

endmodule

// File: rtl/hd10_rx_steer.sv
module hd10_rx_steer #(
    parameter int NIB_W = 4
) (
    input  logic             loop_ok,
    input  logic             tx_en,
    input  logic             rx_active,
    input  logic             coll_det,
    input  logic [NIB_W-1:0] txd,
    input  logic [NIB_W-1:0] line_rxd,
    output logic [NIB_W-1:0] rxd
);
    logic take_tx;

    always_comb begin
        take_tx = loop_ok & tx_en & ~rx_active & ~coll_det;
        rxd     = take_tx ? txd : line_rxd;
    end

endmodule

// File: rtl/hd10_crs_gen.sv
module hd10_crs_gen (
    input  logic half_eff,
    input  logic rptr,
    input  logic tx_en,
    input  logic rx_active,
    output logic crs
);
    always_comb begin
        if (rptr || !half_eff) crs = rx_active;
        else                   crs = rx_active | tx_en;
    end

endmodule

// File: rtl/hd10_sqe_ctrl.sv
module hd10_sqe_ctrl
    import hd10_pkg::*;
#(
    parameter int CLK_FREQ_MHZ = 25,
    parameter int NIB_W        = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    input  logic [NIB_W-1:0] line_rxd,
    input  logic             rx_active,
    input  logic             coll_det,
    input  logic             mode_10bt,
    input  logic             half_dup,
    input  logic             rptr_mode,
    input  logic             sqe_off,
    input  logic             lpbk_en,
    output logic             col,
    output logic             crs,
    output logic [NIB_W-1:0] rxd
);
    localparam int CYC_PER_US = CLK_FREQ_MHZ;

    port_mode_t mode;
    logic hb_on;

    assign mode = '{ten_base: mode_10bt, half: half_dup, rptr: rptr_mode,
                    hb_off: sqe_off, lpbk: lpbk_en};

    hd10_hb_timer #(.CYC_PER_US(CYC_PER_US)) i_timer (
        .clk    (clk),
        .rst    (rst),
        .tx_en  (tx_en),
        .arm_ok (hb_allowed(mode)),
        .hb_on  (hb_on)
    );

    hd10_rx_steer #(.NIB_W(NIB_W)) i_steer (
        .loop_ok   (loop_allowed(mode)),
        .tx_en     (tx_en),
        .rx_active (rx_active),
        .coll_det  (coll_det),
        .txd       (txd),
        .line_rxd  (line_rxd),
        .rxd       (rxd)
    );

    hd10_crs_gen i_crs (
        .half_eff  (eff_half(mode)),
        .rptr      (rptr_mode),
        .tx_en     (tx_en),
        .rx_active (rx_active),
        .crs       (crs)
    );

    assign col = coll_det | hb_on;

endmodule

// File: rtl/hd10_sqe_checker.sv
module hd10_sqe_checker #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_en,
    input logic             rx_active,
    input logic             coll_det,
    input logic             mode_10bt,
    input logic             rptr_mode,
    input logic             sqe_off,
    input logic [NIB_W-1:0] line_rxd,
    input logic             col,
    input logic             crs,
    input logic [NIB_W-1:0] rxd,
    input logic             hb_on
);
    p_hb_off_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        sqe_off |=> !hb_on);

    p_rptr_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        rptr_mode |=> !hb_on);

    p_mode_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !mode_10bt |=> !hb_on);

    p_rise_cancels_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_en) |=> !hb_on);

    p_coll_reaches_col_r7: assert property (@(posedge clk) disable iff (rst)
        coll_det |-> col);

    p_line_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (coll_det || rx_active) |-> (rxd == line_rxd));

    p_rptr_crs_r12: assert property (@(posedge clk) disable iff (rst)
        rptr_mode |-> (crs == rx_active));

endmodule

bind hd10_sqe_ctrl hd10_sqe_checker #(.NIB_W(NIB_W)) i_sqe_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .rx_active (rx_active),
    .coll_det  (coll_det),
    .mode_10bt (mode_10bt),
    .rptr_mode (rptr_mode),
    .sqe_off   (sqe_off),
    .line_rxd  (line_rxd),
    .col       (col),
    .crs       (crs),
    .rxd       (rxd),
    .hb_on     (hb_on)
);

// File: tb/test_hd10_sqe_ctrl.sv
module test_hd10_sqe_ctrl;
    localparam int MHZ = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst, tx_en, rx_active, coll_det;
    logic       mode_10bt, half_dup, rptr_mode, sqe_off, lpbk_en;
    logic [3:0] txd, line_rxd, rxd;
    logic       col, crs;

    int checks = 0;
    int errors = 0;

    hd10_sqe_ctrl #(.CLK_FREQ_MHZ(MHZ), .NIB_W(4)) i_hd10_sqe_ctrl (
        .clk(clk), .rst(rst), .tx_en(tx_en), .txd(txd), .line_rxd(line_rxd),
        .rx_active(rx_active), .coll_det(coll_det), .mode_10bt(mode_10bt),
        .half_dup(half_dup), .rptr_mode(rptr_mode), .sqe_off(sqe_off),
        .lpbk_en(lpbk_en), .col(col), .crs(crs), .rxd(rxd)
    );

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Starts at a negedge with tx_en high for at least two cycles.
    task automatic run_fall(input string req, input bit want, input int abort_at,
                            input int off_at);
        tx_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n < 2 * MHZ + 3; n++) begin
            bit exp;
            exp = want && (n >= MHZ) && (n < 2 * MHZ)
                  && !(abort_at >= 0 && n > abort_at)
                  && !(off_at >= 0 && n > off_at);
            chk(req, {3'b0, col}, {3'b0, exp});
            if (n == abort_at) tx_en = 1'b1;
            if (n == off_at) sqe_off = 1'b1;
            @(negedge clk);
        end
        tx_en = 1'b1;
        repeat (2 * MHZ + 2) @(negedge clk);
        sqe_off = 1'b0;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; tx_en = 1'b0; rx_active = 1'b0; coll_det = 1'b0;
        mode_10bt = 1'b1; half_dup = 1'b1; rptr_mode = 1'b0; sqe_off = 1'b0;
        lpbk_en = 1'b0; txd = 4'h3; line_rxd = 4'hC;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: quiet after reset
        for (int k = 0; k < 3 * MHZ; k++) begin
            @(negedge clk);
            chk("R1 col after reset", {3'b0, col}, 4'h0);
        end
        chk("R1 crs after reset", {3'b0, crs}, 4'h0);
        chk("R1 rxd after reset", rxd, 4'hC);

        tx_en = 1'b1;
        repeat (2) @(negedge clk);

        // R2..R5: heartbeat over mode, disable and repeater combinations
        for (int c = 0; c < 8; c++) begin
            mode_10bt = c[0];
            sqe_off   = c[1];
            rptr_mode = c[2];
            repeat (2) @(negedge clk);
            run_fall(!c[0] ? "R5 heartbeat mode off" : c[2] ? "R4 heartbeat repeater" :
                     c[1] ? "R3 heartbeat disabled" : "R2 heartbeat timing",
                     c[0] && !c[1] && !c[2], -1, -1);
            sqe_off = 1'b0;
        end
        mode_10bt = 1'b1; sqe_off = 1'b0; rptr_mode = 1'b0;

        // R6: cancel at every point of the window
        for (int a = 0; a < 2 * MHZ; a++)
            run_fall("R6 cancel on transmit rise", 1'b1, a, -1);

        // R3: disable during every point of the window
        for (int a = 0; a < 2 * MHZ; a++)
            run_fall("R3 disable mid window", 1'b1, -1, a);

        // R4: repeater set mid window
        tx_en = 1'b0;
        @(posedge clk);
        repeat (MHZ + 1) @(negedge clk);
        chk("R2 pulse high before repeater", {3'b0, col}, 4'h1);
        rptr_mode = 1'b1;
        @(negedge clk);
        chk("R4 repeater mid window", {3'b0, col}, 4'h0);
        rptr_mode = 1'b0;
        tx_en = 1'b1;
        repeat (2 * MHZ + 2) @(negedge clk);

        // R7..R12: combinational sweep over every input combination
        for (int v = 0; v < 256; v++) begin
            bit m10, hd, rp, so, lb, te, ra, cd, eh, lp, ecrs;
            {m10, hd, rp, so, lb, te, ra, cd} = v[7:0];
            mode_10bt = m10; half_dup = hd; rptr_mode = rp; sqe_off = so;
            lpbk_en = lb; tx_en = te; rx_active = ra; coll_det = cd;
            txd = v[3:0] ^ 4'h5;
            line_rxd = v[3:0] ^ 4'hF;
            #1;
            eh   = hd | rp;
            lp   = m10 & eh & lb & te & !ra & !cd;
            ecrs = (eh && !rp) ? (ra | te) : ra;
            if (lp)
                chk("R8 loopback data", rxd, v[3:0] ^ 4'h5);
            else if (ra || cd)
                chk("R9 line data on activity", rxd, v[3:0] ^ 4'hF);
            else if (rp && !hd)
                chk("R12 repeater forces half duplex", rxd, v[3:0] ^ 4'hF);
            else
                chk("R10 line data", rxd, v[3:0] ^ 4'hF);
            if (rp && m10 && lb && te && !ra && !cd)
                chk("R12 repeater loopback", rxd, v[3:0] ^ 4'h5);
            chk(rp ? "R12 repeater crs" : "R11 crs", {3'b0, crs}, {3'b0, ecrs});
            if (cd) chk("R7 collision to col", {3'b0, col}, 4'h1);
            @(negedge clk);
        end

        summary();
        $finish;
    end

endmodule